// File: doc/BRIEF.md
# Complementary Leg Gate Controller with Dead Time and Pulse Rejection

This block drives the two complementary switches of one converter leg. The high-side and low-side switches each have their own PWM command input, so each one is controlled on its own terms. Neither gate is derived as the inverse of the other. Both command bits pass through a two-flop synchronizer. A width qualifier then accepts a new command pair only after it has held steady for a programmable number of clock cycles. Shorter pulses and notches are discarded.

A five-state machine acts on the qualified pair. The states are `LEG_OFF` (both gates off), `LEG_HIGH` (high gate on), `LEG_LOW` (low gate on), `LEG_GAP_HIGH` (blanking before the high gate turns on) and `LEG_GAP_LOW` (blanking before the low gate turns on). The transitions are:

- `LEG_OFF` goes to `LEG_GAP_HIGH` on a qualified pair hi=1, lo=0.
- `LEG_OFF` goes to `LEG_GAP_LOW` on a qualified pair hi=0, lo=1.
- `LEG_HIGH` goes to `LEG_GAP_LOW` on a qualified pair 0/1 (handover). On 0/0 or 1/1 it goes to `LEG_OFF`.
- `LEG_LOW` goes to `LEG_GAP_HIGH` on a qualified pair 1/0 (handover). On 0/0 or 1/1 it goes to `LEG_OFF`.
- A gap state goes to its on-state once the blanking count expires.
- A gap state goes to `LEG_OFF` (abort) as soon as the qualified pair stops requesting its target switch.

A qualified pair with both bits high is illegal. It forces both gates off and raises a one-cycle fault pulse.

Top module: `dtl_leg_ctrl`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both high in any cycle.
- R2: While `rst` is high at a clock edge, the machine enters `LEG_OFF`, and `gate_hi`, `gate_lo` and `fault` are low after that edge.
- R3: From an idle leg, a command change held long enough reaches the gate after exactly M+D+4 rising edges. The edges are counted from the first edge that samples the new command. M = max(`min_width`,1) and D = max(`dead_cycles`,1).
- R4: A command pulse, or a notch in a held command, that lasts fewer than M cycles leaves both gates unchanged.
- R5: On a handover from one switch to the other, both gates are low for exactly D consecutive cycles before the incoming gate rises. No gate ever rises without at least D preceding both-off cycles.
- R6: A `dead_cycles` value of 0 gives a blanking interval of one cycle.
- R7: A qualified pair with `cmd_hi`=1 and `cmd_lo`=1 forces both gates low. In the same cycle, `fault` is high for exactly one cycle, however long the pair persists.
- R8: If the qualified command stops requesting the target switch during blanking, the leg returns to `LEG_OFF`. The original switch is not turned on.
- R9: A qualified 0/0 pair turns the active gate off and keeps both gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 1 | High-side switch command |
| cmd_lo | input | 1 | Low-side switch command |
| dead_cycles | input | 8 | Blanking interval in cycles (0 means 1) |
| min_width | input | 8 | Minimum accepted command width in cycles (0 means 1) |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| fault | output | 1 | One-cycle pulse on an illegal both-on command |

## Verification
A command change reaches the qualified pair M+2 edges after the input is first sampled. The machine reacts one edge later. A gate turns on D edges after that, and a fault pulse appears on the same edge as the forced turn-off. The bench therefore expects a turn-on M+D+4 edges after a change, a fault one edge after qualification, and a handover gap of exactly D both-off samples. It drives inputs on falling edges and samples outputs on the next falling edge, so every expected edge count maps onto a whole number of sampled cycles. A cycle-level reference model, built from these latencies, is compared with the outputs in every sampled cycle during the constrained-random phases.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

    localparam int unsigned CNT_W = 8;

    typedef enum logic [2:0] {
        LEG_OFF      = 3'd0,
        LEG_HIGH     = 3'd1,
        LEG_LOW      = 3'd2,
        LEG_GAP_HIGH = 3'd3,
        LEG_GAP_LOW  = 3'd4
    } leg_state_t;

    // Command pair packing: bit 1 = high side, bit 0 = low side
    localparam logic [1:0] PAIR_OFF  = 2'b00;
    localparam logic [1:0] PAIR_LOW  = 2'b01;
    localparam logic [1:0] PAIR_HIGH = 2'b10;
    localparam logic [1:0] PAIR_BAD  = 2'b11;

endpackage

// File: rtl/dtl_sync.sv
module dtl_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dtl_width_qual.sv
module dtl_width_qual #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned CW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    input  logic [CW-1:0]    min_width,
    output logic [WIDTH-1:0] qual
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [WIDTH-1:0] cand;
    logic [CW-1:0]    run_len;
    logic             long_enough;

    // A zero setting behaves like one cycle because run_len is at least 1
    assign long_enough = (run_len >= min_width) && (run_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= '0;
            run_len <= '0;
        end else if (raw != cand) begin
            cand    <= raw;
            run_len <= {{(CW-1){1'b0}}, 1'b1};
        end else if (run_len != CNT_MAX) begin
            run_len <= run_len + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              qual <= '0;
        else if (long_enough) qual <= cand;
    end
endmodule

// File: rtl/dtl_leg_fsm.sv
module dtl_leg_fsm
    import dtl_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    pair,
    input  logic [CW-1:0] dead_cycles,
    output logic          gate_hi,
    output logic          gate_lo,
    output logic          fault
);
    leg_state_t    state, state_nx;
    logic [CW-1:0] gap_left;
    logic [CW-1:0] gap_load;
    logic [1:0]    pair_prev;
    logic          gap_done;
    logic          entering_gap;

    assign gap_load = (dead_cycles == '0) ? {{(CW-1){1'b0}}, 1'b1} : dead_cycles;
    assign gap_done = (gap_left <= {{(CW-1){1'b0}}, 1'b1});

    always_comb begin
        state_nx = state;
        unique case (state)
            LEG_OFF: begin
                if (pair == PAIR_HIGH)     state_nx = LEG_GAP_HIGH;
                else if (pair == PAIR_LOW) state_nx = LEG_GAP_LOW;
            end
            LEG_HIGH: begin
                if (pair == PAIR_LOW)       state_nx = LEG_GAP_LOW;
                else if (pair != PAIR_HIGH) state_nx = LEG_OFF;
            end
            LEG_LOW: begin
                if (pair == PAIR_HIGH)     state_nx = LEG_GAP_HIGH;
                else if (pair != PAIR_LOW) state_nx = LEG_OFF;
            end
            LEG_GAP_HIGH: begin
                if (pair != PAIR_HIGH) state_nx = LEG_OFF;
                else if (gap_done)     state_nx = LEG_HIGH;
            end
            LEG_GAP_LOW: begin
                if (pair != PAIR_LOW) state_nx = LEG_OFF;
                else if (gap_done)    state_nx = LEG_LOW;
            end
            default: state_nx = LEG_OFF;
        endcase
    end

    assign entering_gap = ((state_nx == LEG_GAP_HIGH) || (state_nx == LEG_GAP_LOW))
                          && (state_nx != state);

    // State register and blanking counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LEG_OFF;
            gap_left <= '0;
        end else begin
            state <= state_nx;
            if (entering_gap)
                gap_left <= gap_load;
            else if ((state == LEG_GAP_HIGH) || (state == LEG_GAP_LOW))
                gap_left <= gap_left - 1'b1;
        end
    end

    // Illegal pair detector: one pulse per arrival of the both-on pair
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_prev <= PAIR_OFF;
            fault     <= 1'b0;
        end else begin
            pair_prev <= pair;
            fault     <= (pair == PAIR_BAD) && (pair_prev != PAIR_BAD);
        end
    end

    // Gate outputs decoded from the state register only
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state)
            LEG_HIGH: gate_hi = 1'b1;
            LEG_LOW:  gate_lo = 1'b1;
            default: begin
                gate_hi = 1'b0;
                gate_lo = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dtl_leg_ctrl.sv
module dtl_leg_ctrl
    import dtl_pkg::*;
#(
    parameter int unsigned CW          = CNT_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_hi,
    input  logic          cmd_lo,
    input  logic [CW-1:0] dead_cycles,
    input  logic [CW-1:0] min_width,
    output logic          gate_hi,
    output logic          gate_lo,
    output logic          fault
);
    localparam int unsigned PAIR_W = 2;

    logic [PAIR_W-1:0] pair_sync;
    logic [PAIR_W-1:0] pair_qual;

    dtl_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cmd_hi, cmd_lo}),
        .q   (pair_sync)
    );

    dtl_width_qual #(.WIDTH(PAIR_W), .CW(CW)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .raw       (pair_sync),
        .min_width (min_width),
        .qual      (pair_qual)
    );

    dtl_leg_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pair        (pair_qual),
        .dead_cycles (dead_cycles),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .fault       (fault)
    );
endmodule

// File: rtl/dtl_leg_checker.sv
module dtl_leg_checker #(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] dead_cycles,
    input logic          gate_hi,
    input logic          gate_lo,
    input logic          fault
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic [CW-1:0] off_run;
    logic [CW-1:0] need;

    assign need = (dead_cycles == '0) ? {{(CW-1){1'b0}}, 1'b1} : dead_cycles;

    always_ff @(posedge clk) begin
        if (rst)                      off_run <= '0;
        else if (gate_hi || gate_lo)  off_run <= '0;
        else if (off_run != SAT)      off_run <= off_run + 1'b1;
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    a_r2_reset_off: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!gate_hi && !gate_lo && !fault));

    a_r5_gap_before_high: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> (off_run >= need));

    a_r5_gap_before_low: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> (off_run >= need));

    a_r7_fault_single: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    a_r7_fault_gates_off: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!gate_hi && !gate_lo));
endmodule

bind dtl_leg_ctrl dtl_leg_checker #(.CW(CW)) u_leg_chk (
    .clk         (clk),
    .rst         (rst),
    .dead_cycles (dead_cycles),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .fault       (fault)
);

// File: tb/tb_dtl_leg_ctrl.sv
module tb_dtl_leg_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_hi = 1'b0;
    logic       cmd_lo = 1'b0;
    logic [7:0] dead_cycles = 8'd5;
    logic [7:0] min_width = 8'd3;
    logic       gate_hi, gate_lo, fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit model_on = 1'b0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtl_leg_ctrl dut (
        .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .dead_cycles(dead_cycles), .min_width(min_width),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
    );

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: timing per R3/R5/R7/R8
    logic [1:0] m_d1, m_d2, m_seen, m_q, m_qp;
    int         m_run, m_gap;
    int         m_st;   // 0 off, 1 high, 2 low, 3 gap-high, 4 gap-low
    logic       m_fault;

    always @(posedge clk) begin
        if (rst) begin
            m_d1 <= 2'b00; m_d2 <= 2'b00; m_seen <= 2'b00; m_q <= 2'b00;
            m_qp <= 2'b00; m_run <= 0; m_gap <= 0; m_st <= 0; m_fault <= 1'b0;
        end else begin
            m_d1 <= {cmd_hi, cmd_lo};
            m_d2 <= m_d1;
            if (m_d2 != m_seen) begin
                m_seen <= m_d2; m_run <= 1;
            end else if (m_run < 255) m_run <= m_run + 1;
            if (m_run >= eff(min_width)) m_q <= m_seen;
            m_qp    <= m_q;
            m_fault <= (m_q == 2'b11) && (m_qp != 2'b11);
            case (m_st)
                0: if (m_q == 2'b10) begin m_st <= 3; m_gap <= eff(dead_cycles); end
                   else if (m_q == 2'b01) begin m_st <= 4; m_gap <= eff(dead_cycles); end
                1: if (m_q == 2'b01) begin m_st <= 4; m_gap <= eff(dead_cycles); end
                   else if (m_q != 2'b10) m_st <= 0;
                2: if (m_q == 2'b10) begin m_st <= 3; m_gap <= eff(dead_cycles); end
                   else if (m_q != 2'b01) m_st <= 0;
                3: if (m_q != 2'b10) m_st <= 0;
                   else if (m_gap <= 1) m_st <= 1;
                   else m_gap <= m_gap - 1;
                default: if (m_q != 2'b01) m_st <= 0;
                   else if (m_gap <= 1) m_st <= 2;
                   else m_gap <= m_gap - 1;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R1/R5 model gate_hi", int'(gate_hi), int'(m_st == 1));
            check("R1/R5 model gate_lo", int'(gate_lo), int'(m_st == 2));
            check("R7 model fault", int'(fault), int'(m_fault));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cmd(input logic h, input logic l);
        cmd_hi = h; cmd_lo = l;
    endtask

    task automatic do_reset(input logic [7:0] dt, input logic [7:0] mw);
        rst = 1'b1; set_cmd(1'b0, 1'b0); dead_cycles = dt; min_width = mw;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    // Count posedges until a gate is seen high
    task automatic time_to_on(input bit hi_side, output int n);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (hi_side ? gate_hi : gate_lo) break;
        end
    endtask

    task automatic off_gap(output int n);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (gate_lo || gate_hi) begin
                if (n > 0) break;
            end else n++;
        end
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 150000);
                if (!done) begin
                    n_checks++; n_fail++;
                    $display("FAIL watchdog actual=hung expected=finished");
                    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        int n, hits;
        @(negedge clk);
        // R2 reset state
        do_reset(8'd5, 8'd3);
        check("R2 gate_hi after reset", int'(gate_hi), 0);
        check("R2 gate_lo after reset", int'(gate_lo), 0);
        check("R2 fault after reset", int'(fault), 0);
        model_on = 1'b1;

        // R3 latency from idle: M+D+4
        set_cmd(1'b1, 1'b0);
        time_to_on(1'b1, n);
        check("R3 turn-on latency", n, 3 + 5 + 4);

        // R4 notch of M-1 cycles in a held high command
        cycles(3);
        set_cmd(1'b0, 1'b0); cycles(2); set_cmd(1'b1, 1'b0);
        hits = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (!gate_hi) hits++; end
        check("R4 notch ignored, gate_hi low samples", hits, 0);

        // R5 handover high->low gap of exactly D
        set_cmd(1'b0, 1'b1);
        off_gap(n);
        check("R5 handover gap cycles", n, 5);
        check("R1 only low gate on", int'(gate_hi), 0);

        // R9 0/0 turns the leg off
        set_cmd(1'b0, 1'b0); cycles(20);
        check("R9 gate_lo off", int'(gate_lo), 0);
        check("R9 gate_hi off", int'(gate_hi), 0);

        // R4 short pulse from idle
        set_cmd(1'b0, 1'b1); cycles(2); set_cmd(1'b0, 1'b0);
        hits = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (gate_lo || gate_hi) hits++; end
        check("R4 short pulse ignored", hits, 0);

        // R7 both high from an on state
        set_cmd(1'b1, 1'b0); cycles(30);
        set_cmd(1'b1, 1'b1);
        hits = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (fault) hits++; end
        check("R7 single fault pulse", hits, 1);
        check("R7 gates off hi", int'(gate_hi), 0);
        check("R7 gates off lo", int'(gate_lo), 0);
        set_cmd(1'b0, 1'b0); cycles(20);

        // R6 zero dead time acts as one
        model_on = 1'b0;
        do_reset(8'd0, 8'd1);
        model_on = 1'b1;
        set_cmd(1'b1, 1'b0); time_to_on(1'b1, n);
        check("R6 latency with zero dead time", n, 1 + 1 + 4);
        set_cmd(1'b0, 1'b1); off_gap(n);
        check("R6 gap with zero dead time", n, 1);
        set_cmd(1'b0, 1'b0); cycles(10);

        // R8 revert during blanking
        model_on = 1'b0;
        do_reset(8'd20, 8'd1);
        model_on = 1'b1;
        set_cmd(1'b1, 1'b0); cycles(6); set_cmd(1'b0, 1'b0);
        hits = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (gate_hi || gate_lo) hits++; end
        check("R8 abort during blanking", hits, 0);

        // Constrained random phases checked against the model
        void'($urandom(32'd1234));
        for (int ph = 0; ph < 4; ph++) begin
            model_on = 1'b0;
            do_reset(8'($urandom_range(0, 12)), 8'($urandom_range(0, 6)));
            model_on = 1'b1;
            for (int k = 0; k < 150; k++) begin
                int r;
                r = int'($urandom_range(0, 9));
                if (r < 4)      set_cmd(1'b1, 1'b0);
                else if (r < 8) set_cmd(1'b0, 1'b1);
                else if (r < 9) set_cmd(1'b0, 1'b0);
                else            set_cmd(1'b1, 1'b1);
                cycles(int'($urandom_range(1, 25)));
            end
            set_cmd(1'b0, 1'b0); cycles(30);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule